// File: doc/BRIEF.md
# Compare Timer with Self-Rearming Auto-Increment Mode

This block is a word-addressed system timer that watches a free-running 64-bit count driven from outside. Software programs a 64-bit compare value, either as an absolute value in two halves or as a signed 32-bit offset from the current count. The block raises a level interrupt once the count has reached that value. The relative view can be read back as the low 32 bits of the distance still to go.

A second mode uses an auto-increment comparator in place of the compare value. When the mode is entered, the comparator is armed at the current count plus a 32-bit reload amount. Each time the count reaches the armed point, a sticky flag is set and the comparator re-arms itself at count plus reload. While this mode is active, the status bit and the interrupt follow the sticky flag and the compare value has no effect. Software clears the flag by writing 0 to it.

Operation is built around a three-state mode machine: `MODE_OFF` (main enable clear), `MODE_CMP` (enabled, auto-increment off) and `MODE_AUTO` (both enables set). The next state is taken from the two enable bits. Any transition into `MODE_AUTO` from `MODE_OFF` or `MODE_CMP` produces a one-cycle arm pulse. The transitions back out (`MODE_AUTO` to `MODE_CMP` or `MODE_OFF`, and between `MODE_OFF` and `MODE_CMP`) carry no side effect. The mode register follows the enable bits one cycle after the write that changes them.

Top module: `cmp_timer`

## Requirements
- R1: After reset the frequency, control, compare, reload, auto-increment control and auto-increment value registers all read 0, and `irq_o` is 0.
- R2: Byte offsets 0x00 and 0x04 return the low and high words of `count_i`, which is registered once inside the block.
- R3: At the control word 0x2C, bit 0 is enable and bit 1 is mask, and only these two bits are stored. Bit 2 reads the current status and cannot be written. All other bits read 0.
- R4: In `MODE_CMP`, status is 1 when the registered count is at least the 64-bit compare value (offsets 0x20 low and 0x24 high), compared as unsigned numbers. In `MODE_OFF`, status is 0.
- R5: `irq_o` is a register loaded with status AND NOT mask. It therefore rises on the second clock edge after the edge that brings in a count meeting the condition.
- R6: A read of offset 0x28 returns the low 32 bits of (compare minus count). A write to 0x28 sets compare to count plus the sign-extended written word.
- R7: At offset 0x4C, bit 0 is a read/write auto-increment enable and bit 1 is the sticky fire flag. Writing 0 to bit 1 clears the flag, and writing 1 to bit 1 leaves it unchanged.
- R8: On entry to `MODE_AUTO`, the auto-increment value (offsets 0x40 low and 0x44 high) is loaded with count plus the 32-bit reload value written at 0x48.
- R9: In `MODE_AUTO`, a count at or above the auto-increment value sets the flag and reloads the auto-increment value with count plus reload. Status follows the flag, and the compare value is ignored.
- R10: Offset 0x50 reads 1. Offset 0x10 is a 32-bit read/write frequency word. Writes to the count words, the auto-increment value words, 0x50 and unmapped offsets are ignored. Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| count_i | input | 64 | Free-running count value |
| addr_i | input | 12 | Byte offset of the accessed word |
| wr_en_i | input | 1 | Write strobe for the word at `addr_i` |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Level interrupt |

## Verification
The assertions assume that `count_i` is settled at each clock edge and that a write affects only the single word addressed in that cycle. They also assume the mode register trails the enable bits by exactly one cycle, so that the arm pulse always lands in `MODE_AUTO`. The stimulus holds `count_i` still around every write to the relative view and every enable change. It changes the count only between bus operations and waits several cycles before each sample, so each expected value depends on one register update alone.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic [1:0] {
        MODE_OFF  = 2'd0,
        MODE_CMP  = 2'd1,
        MODE_AUTO = 2'd2
    } mode_e;

    localparam int OFF_CNT_LO  = 'h00;
    localparam int OFF_CNT_HI  = 'h04;
    localparam int OFF_FREQ    = 'h10;
    localparam int OFF_CMP_LO  = 'h20;
    localparam int OFF_CMP_HI  = 'h24;
    localparam int OFF_REL     = 'h28;
    localparam int OFF_CTL     = 'h2C;
    localparam int OFF_AIV_LO  = 'h40;
    localparam int OFF_AIV_HI  = 'h44;
    localparam int OFF_RELOAD  = 'h48;
    localparam int OFF_AICTL   = 'h4C;
    localparam int OFF_CFG     = 'h50;
    localparam int CFG_VALUE   = 1;
endpackage

// File: rtl/tmr_ge.sv
module tmr_ge #(
    parameter int W = 64
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic         ge_o
);
    always_comb ge_o = (a_i >= b_i);
endmodule

// File: rtl/tmr_mode_fsm.sv
module tmr_mode_fsm
    import tmr_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  en_i,
    input  logic  ai_en_i,
    output mode_e mode_o,
    output logic  arm_o
);
    mode_e state_q, state_d;

    always_comb begin
        unique case ({en_i, ai_en_i})
            2'b11:   state_d = MODE_AUTO;
            2'b10:   state_d = MODE_CMP;
            default: state_d = MODE_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= MODE_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        mode_o = state_q;
        arm_o  = 1'b0;
        unique case (state_q)
            MODE_OFF:  arm_o = (state_d == MODE_AUTO);
            MODE_CMP:  arm_o = (state_d == MODE_AUTO);
            MODE_AUTO: arm_o = 1'b0;
            default:   arm_o = 1'b0;
        endcase
    end

    // R8: an arm pulse always lands in the auto-increment state
    assert_arm_enters_auto_R8: assert property (@(posedge clk) disable iff (!rst_n)
        arm_o |=> (mode_o == MODE_AUTO));
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
    import tmr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 12,
    localparam int CNT_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  count_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              irq_o
);
    logic [CNT_W-1:0]  cnt_q, cmp_q, aiv_q;
    logic [DATA_W-1:0] freq_q, reload_q;
    logic              en_q, mask_q, ai_en_q, flag_q, irq_q;
    logic              cmp_ge, aiv_ge, arm, fire, status;
    logic [CNT_W-1:0]  next_aiv, rel_sext, rel_view;
    mode_e             mode;

    function automatic logic hit(input logic [ADDR_W-1:0] a, input int off);
        return a == ADDR_W'(off);
    endfunction

    tmr_ge #(.W(CNT_W)) u_cmp_ge (.a_i(cnt_q), .b_i(cmp_q), .ge_o(cmp_ge));
    tmr_ge #(.W(CNT_W)) u_aiv_ge (.a_i(cnt_q), .b_i(aiv_q), .ge_o(aiv_ge));

    tmr_mode_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .en_i(en_q), .ai_en_i(ai_en_q),
        .mode_o(mode), .arm_o(arm)
    );

    always_comb begin
        next_aiv = cnt_q + CNT_W'(reload_q);
        rel_sext = {{DATA_W{wr_data_i[DATA_W-1]}}, wr_data_i};
        rel_view = cmp_q - cnt_q;
        fire     = (mode == MODE_AUTO) && aiv_ge;
        unique case (mode)
            MODE_OFF:  status = 1'b0;
            MODE_CMP:  status = cmp_ge;
            MODE_AUTO: status = flag_q;
            default:   status = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            cmp_q    <= '0;
            aiv_q    <= '0;
            freq_q   <= '0;
            reload_q <= '0;
            en_q     <= 1'b0;
            mask_q   <= 1'b0;
            ai_en_q  <= 1'b0;
            flag_q   <= 1'b0;
            irq_q    <= 1'b0;
        end else begin
            cnt_q <= count_i;
            irq_q <= status && !mask_q;
            if (wr_en_i) begin
                if (hit(addr_i, OFF_FREQ))   freq_q   <= wr_data_i;
                if (hit(addr_i, OFF_RELOAD)) reload_q <= wr_data_i;
                if (hit(addr_i, OFF_CMP_LO)) cmp_q[DATA_W-1:0]     <= wr_data_i;
                if (hit(addr_i, OFF_CMP_HI)) cmp_q[CNT_W-1:DATA_W] <= wr_data_i;
                if (hit(addr_i, OFF_REL))    cmp_q <= cnt_q + rel_sext;
                if (hit(addr_i, OFF_CTL)) begin
                    en_q   <= wr_data_i[0];
                    mask_q <= wr_data_i[1];
                end
                if (hit(addr_i, OFF_AICTL)) ai_en_q <= wr_data_i[0];
            end
            if (arm || fire) aiv_q <= next_aiv;
            if (fire)
                flag_q <= 1'b1;
            else if (wr_en_i && hit(addr_i, OFF_AICTL) && !wr_data_i[1])
                flag_q <= 1'b0;
        end
    end

    always_comb begin
        rd_data_o = '0;
        if      (hit(addr_i, OFF_CNT_LO)) rd_data_o = cnt_q[DATA_W-1:0];
        else if (hit(addr_i, OFF_CNT_HI)) rd_data_o = cnt_q[CNT_W-1:DATA_W];
        else if (hit(addr_i, OFF_FREQ))   rd_data_o = freq_q;
        else if (hit(addr_i, OFF_CMP_LO)) rd_data_o = cmp_q[DATA_W-1:0];
        else if (hit(addr_i, OFF_CMP_HI)) rd_data_o = cmp_q[CNT_W-1:DATA_W];
        else if (hit(addr_i, OFF_REL))    rd_data_o = rel_view[DATA_W-1:0];
        else if (hit(addr_i, OFF_CTL))    rd_data_o = DATA_W'({status, mask_q, en_q});
        else if (hit(addr_i, OFF_AIV_LO)) rd_data_o = aiv_q[DATA_W-1:0];
        else if (hit(addr_i, OFF_AIV_HI)) rd_data_o = aiv_q[CNT_W-1:DATA_W];
        else if (hit(addr_i, OFF_RELOAD)) rd_data_o = reload_q;
        else if (hit(addr_i, OFF_AICTL))  rd_data_o = DATA_W'({flag_q, ai_en_q});
        else if (hit(addr_i, OFF_CFG))    rd_data_o = DATA_W'(CFG_VALUE);
    end

    assign irq_o = irq_q;

    // R5: an interrupt is only raised when the mask was clear
    assert_irq_unmasked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> !$past(mask_q));
    // R4: a disabled timer never drives the interrupt
    assert_off_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_OFF) |=> !irq_o);
    // R9: the sticky flag only rises from a fire in auto mode
    assert_flag_from_auto_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(mode == MODE_AUTO));
    // R6: a relative write leaves compare at count plus signed offset
    assert_rel_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && hit(addr_i, OFF_REL)) |=>
        ((cmp_q - $past(cnt_q)) == {{DATA_W{$past(wr_data_i[DATA_W-1])}}, $past(wr_data_i)}));
endmodule

// File: tb/cmp_timer_tb_top.sv
`timescale 1ns/100ps
module cmp_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] count_i = '0;
    logic [11:0] addr_i = '0;
    logic        wr_en_i = 1'b0;
    logic [31:0] wr_data_i = '0;
    logic [31:0] rd_data_o;
    logic        irq_o;
    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    cmp_timer dut_i (
        .clk(clk), .rst_n(rst_n), .count_i(count_i), .addr_i(addr_i),
        .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .rd_data_o(rd_data_o), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        addr_i = a; wr_data_i = d; wr_en_i = 1'b1;
        @(posedge clk); #1;
        wr_en_i = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        addr_i = a; #1;
        d = rd_data_o;
    endtask

    task automatic settle();
        repeat (3) @(posedge clk);
        #1;
    endtask

    task automatic rchk(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic t_reset();
        rchk("R1 ctl", 12'h2C, 0);
        rchk("R1 cmp lo", 12'h20, 0);
        rchk("R1 cmp hi", 12'h24, 0);
        rchk("R1 freq", 12'h10, 0);
        rchk("R1 reload", 12'h48, 0);
        rchk("R1 aictl", 12'h4C, 0);
        rchk("R1 aiv lo", 12'h40, 0);
        chk("R1 irq", irq_o, 0);
    endtask

    task automatic t_map();
        count_i = 64'h1234_5678_9ABC_DEF0;
        settle();
        rchk("R2 count lo", 12'h00, 32'h9ABC_DEF0);
        rchk("R2 count hi", 12'h04, 32'h1234_5678);
        wr(12'h00, 32'h0);
        wr(12'h40, 32'hFFFF);
        wr(12'h50, 32'h7);
        wr(12'h30, 32'hDEAD);
        settle();
        rchk("R10 count ro", 12'h00, 32'h9ABC_DEF0);
        rchk("R10 aiv ro", 12'h40, 0);
        rchk("R10 cfg", 12'h50, 1);
        rchk("R10 unmapped", 12'h30, 0);
        wr(12'h10, 32'h05F5_E100);
        rchk("R10 freq", 12'h10, 32'h05F5_E100);
    endtask

    task automatic t_compare();
        count_i = 64'h1_0000_0000;
        wr(12'h24, 32'h1);
        wr(12'h20, 32'h10);
        wr(12'h2C, 32'h1);
        settle();
        chk("R4 below", irq_o, 0);
        rchk("R3 ctl below", 12'h2C, 32'h1);
        count_i = 64'h1_0000_0010;
        @(posedge clk); #1;
        chk("R5 not yet", irq_o, 0);
        @(posedge clk); #1;
        chk("R5 rises", irq_o, 1);
        rchk("R3 status bit", 12'h2C, 32'h5);
        count_i = 64'h2_0000_0000;
        settle();
        chk("R4 above hi", irq_o, 1);
        wr(12'h2C, 32'h3);
        settle();
        chk("R5 masked", irq_o, 0);
        rchk("R3 masked read", 12'h2C, 32'h7);
        wr(12'h2C, 32'h2);
        settle();
        rchk("R4 disabled", 12'h2C, 32'h2);
        wr(12'h2C, 32'hFFFF_FFF9);
        settle();
        rchk("R3 stored bits", 12'h2C, 32'h5);
        chk("R5 irq on", irq_o, 1);
    endtask

    task automatic t_relative();
        count_i = 64'h5_0000_0100;
        settle();
        wr(12'h28, 32'h40);
        settle();
        rchk("R6 cmp lo", 12'h20, 32'h0000_0140);
        rchk("R6 cmp hi", 12'h24, 32'h5);
        rchk("R6 rel read", 12'h28, 32'h40);
        chk("R4 not reached", irq_o, 0);
        wr(12'h28, 32'hFFFF_FFF0);
        settle();
        rchk("R6 neg lo", 12'h20, 32'h0000_00F0);
        rchk("R6 neg hi", 12'h24, 32'h5);
        rchk("R6 neg rel", 12'h28, 32'hFFFF_FFF0);
        chk("R4 past", irq_o, 1);
    endtask

    task automatic t_auto();
        wr(12'h2C, 32'h0);
        count_i = 64'h100;
        wr(12'h24, 32'h0);
        wr(12'h20, 32'h0);
        wr(12'h48, 32'h50);
        wr(12'h4C, 32'h1);
        settle();
        rchk("R8 no arm while off", 12'h40, 0);
        wr(12'h2C, 32'h1);
        settle();
        rchk("R8 armed lo", 12'h40, 32'h150);
        rchk("R8 armed hi", 12'h44, 0);
        chk("R9 compare ignored", irq_o, 0);
        rchk("R9 status from flag", 12'h2C, 32'h1);
        count_i = 64'h150;
        settle();
        chk("R9 fire irq", irq_o, 1);
        rchk("R9 flag set", 12'h4C, 32'h3);
        rchk("R9 rearmed", 12'h40, 32'h1A0);
        wr(12'h4C, 32'h3);
        settle();
        rchk("R7 write1 keeps", 12'h4C, 32'h3);
        wr(12'h4C, 32'h1);
        settle();
        rchk("R7 write0 clears", 12'h4C, 32'h1);
        chk("R7 irq drops", irq_o, 0);
        wr(12'h4C, 32'h0);
        settle();
        chk("R9 compare back", irq_o, 1);
        wr(12'h48, 32'h20);
        wr(12'h4C, 32'h1);
        settle();
        rchk("R8 rearm on entry", 12'h40, 32'h170);
        chk("R9 flag clear in auto", irq_o, 0);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset();
        t_map();
        t_compare();
        t_relative();
        t_auto();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule